// File: doc/BRIEF.md
# Bidirectional Arithmetic Shifter with Status Flags

This unit performs one arithmetic shift per clock for a fixed-point DSP datapath. A 40-bit source operand (a 32-bit word plus 8 guard bits) is shifted by a signed 7-bit count. The count comes from a register or an immediate field. A positive count shifts left and fills with zeros. A negative count shifts right and extends the sign bit. A count of zero passes the operand through unchanged. The result and its destination register index appear at the outputs one clock after the operation is presented.

Alongside the result, the unit keeps a five-bit status register: a programmable flag `flag_dc`, and the fixed flags `flag_n`, `flag_z`, `flag_v` and `flag_gt`. A 3-bit condition-select input picks what `flag_dc` means: the last bit shifted out, the sign of the result, the zero test, or constant zero. Unconditional operations rewrite the status register from their result. Conditional operations still deliver their result, but leave the status register untouched.

Counts outside the supported window of -32 to +32 give an unspecified result and raise `amt_bad`. In the immediate-count form the first source and the destination must be the same register; when they differ, `imm_mismatch` is raised. The block has no state machine. Its state is the result register stage and the status register, and both clear on reset.

Top module: `ashift_flag_unit`

## Requirements
- R1: A valid operation with a count from +1 to +32 yields, one cycle later, the source multiplied by 2^count modulo 2^40 (zero fill from the right) on `res_data`, with `res_valid` high and `res_dst` equal to the presented `dst_sel`.
- R2: A count from -32 to -1 yields, one cycle later, the floor of the signed 40-bit source divided by 2^(-count) (sign extension from the left).
- R3: A count of zero yields the source unchanged, and the shifted-out bit is then taken as 0.
- R4: `amount` is a 7-bit two's-complement count; `amt_bad` is high in the cycle after a valid operation whose count is below -32 or above +32, and low after any other valid operation.
- R5: `imm_mismatch` is high in the cycle after a valid operation with `op_imm` = 1 and `src1_sel` different from `dst_sel`, and low otherwise.
- R6: A valid operation with `op_cond` = 0 rewrites all five status flags from its own result, visible one cycle later.
- R7: A valid operation with `op_cond` = 1 still produces its result, but all five status flags keep their previous values.
- R8: With `cond_sel` = 3'b000, `flag_dc` becomes the last bit shifted out: source bit 40-count for a left shift, source bit (-count)-1 for a right shift.
- R9: With `cond_sel` = 3'b001, `flag_dc` becomes result bit 39 (negative). With `cond_sel` = 3'b010, it becomes 1 exactly when the result is zero.
- R10: With `cond_sel` of 3'b011, 3'b100, 3'b101, 3'b110 or 3'b111, `flag_dc` is written as 0.
- R11: Whatever `cond_sel` is, `flag_n` becomes result bit 39, `flag_z` becomes the zero test, and `flag_v` and `flag_gt` become 0.
- R12: After reset, `res_valid`, `amt_bad`, `imm_mismatch` and all five flags are 0. `res_valid` is 0 in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_cond | input | 1 | Operation is conditional (status flags not written) |
| op_imm | input | 1 | Count comes from an immediate field |
| src1_sel | input | 3 | Register index of the first source |
| dst_sel | input | 3 | Register index of the destination |
| src_data | input | 40 | Source operand |
| amount | input | 7 | Signed shift count |
| cond_sel | input | 3 | Selects the meaning of `flag_dc` |
| res_valid | output | 1 | Result stage holds an operation |
| res_data | output | 40 | Shift result |
| res_dst | output | 3 | Destination index of the result |
| amt_bad | output | 1 | Count was outside -32..+32 |
| imm_mismatch | output | 1 | Immediate form with source differing from destination |
| flag_dc | output | 1 | Programmable status flag |
| flag_n | output | 1 | Negative status flag |
| flag_z | output | 1 | Zero status flag |
| flag_v | output | 1 | Overflow status flag (always written 0) |
| flag_gt | output | 1 | Greater-than status flag (always written 0) |

## Verification
The bench builds the unit with its default parameters: 40-bit data, a 7-bit count, a 32-step limit and 3-bit register indices. With these values every one of the 128 encodable counts can be swept, so both edges of the valid window (±32, ±33) and the extreme codes -64 and +63 are covered. Each count is combined with six operand patterns that reach sign fill, all-ones propagation and results that become zero. All eight condition-select codes rotate across the sweep, so each `flag_dc` meaning is checked against left, right and zero shifts. Expected results are computed as modular multiplication and floor division.

// File: rtl/ashift_pkg.sv
package ashift_pkg;

    typedef enum logic [2:0] {
        CS_SHOUT = 3'b000,
        CS_NEG   = 3'b001,
        CS_ZERO  = 3'b010,
        CS_OVF   = 3'b011,
        CS_GT    = 3'b100,
        CS_GE    = 3'b101,
        CS_RSV6  = 3'b110,
        CS_RSV7  = 3'b111
    } dc_mode_e;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } stat_flags_t;

endpackage

// File: rtl/ashift_core.sv
module ashift_core #(
    parameter int DATA_W = 40,
    parameter int AMT_W  = 7
) (
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] result,
    output logic              shout
);
    logic              amt_neg;
    logic [AMT_W-1:0]  mag;
    logic [DATA_W:0]   left_t;
    logic [DATA_W:0]   right_t;

    assign amt_neg = amount[AMT_W-1];

    always_comb begin
        mag     = amt_neg ? AMT_W'(-amount) : amount;
        left_t  = {1'b0, src} << mag;
        right_t = $unsigned($signed({src, 1'b0}) >>> mag);
        if (mag == '0) begin
            result = src;
            shout  = 1'b0;
        end else if (amt_neg) begin
            result = right_t[DATA_W:1];
            shout  = right_t[0];
        end else begin
            result = left_t[DATA_W-1:0];
            shout  = left_t[DATA_W];
        end
    end
endmodule

// File: rtl/ashift_flag_sel.sv
module ashift_flag_sel
    import ashift_pkg::*;
#(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] result,
    input  logic              shout,
    input  logic [2:0]        cond_sel,
    output stat_flags_t       flags
);
    logic     is_neg;
    logic     is_zero;
    dc_mode_e mode;

    assign is_neg  = result[DATA_W-1];
    assign is_zero = (result == '0);
    assign mode    = dc_mode_e'(cond_sel);

    always_comb begin
        flags.n  = is_neg;
        flags.z  = is_zero;
        flags.v  = 1'b0;
        flags.gt = 1'b0;
        unique case (mode)
            CS_SHOUT: flags.dc = shout;
            CS_NEG:   flags.dc = is_neg;
            CS_ZERO:  flags.dc = is_zero;
            default:  flags.dc = 1'b0;
        endcase
    end
endmodule

// File: rtl/ashift_stat_reg.sv
module ashift_stat_reg
    import ashift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  stat_flags_t next_flags,
    output stat_flags_t cur_flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_flags <= '0;
        else if (wr_en)
            cur_flags <= next_flags;
    end

    assert_hold_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> cur_flags == $past(cur_flags));
endmodule

// File: rtl/ashift_flag_unit.sv
module ashift_flag_unit
    import ashift_pkg::*;
#(
    parameter int DATA_W    = 40,
    parameter int AMT_W     = 7,
    parameter int MAX_SHIFT = 32,
    parameter int REG_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_cond,
    input  logic              op_imm,
    input  logic [REG_W-1:0]  src1_sel,
    input  logic [REG_W-1:0]  dst_sel,
    input  logic [DATA_W-1:0] src_data,
    input  logic [AMT_W-1:0]  amount,
    input  logic [2:0]        cond_sel,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [REG_W-1:0]  res_dst,
    output logic              amt_bad,
    output logic              imm_mismatch,
    output logic              flag_dc,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_gt
);
    localparam int AMT_HI = MAX_SHIFT;
    localparam int AMT_LO = -MAX_SHIFT;

    logic [DATA_W-1:0] shift_res;
    logic              shift_out;
    logic              range_bad;
    logic              sel_clash;
    logic              flag_wr;
    stat_flags_t       new_flags;
    stat_flags_t       cur_flags;

    ashift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .src    (src_data),
        .amount (amount),
        .result (shift_res),
        .shout  (shift_out)
    );

    ashift_flag_sel #(.DATA_W(DATA_W)) u_fsel (
        .result   (shift_res),
        .shout    (shift_out),
        .cond_sel (cond_sel),
        .flags    (new_flags)
    );

    assign flag_wr = op_valid && !op_cond;

    ashift_stat_reg u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (flag_wr),
        .next_flags (new_flags),
        .cur_flags  (cur_flags)
    );

    always_comb begin
        range_bad = (int'($signed(amount)) > AMT_HI) || (int'($signed(amount)) < AMT_LO);
        sel_clash = op_imm && (src1_sel != dst_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_data     <= '0;
            res_dst      <= '0;
            amt_bad      <= 1'b0;
            imm_mismatch <= 1'b0;
        end else begin
            res_valid    <= op_valid;
            amt_bad      <= op_valid && range_bad;
            imm_mismatch <= op_valid && sel_clash;
            if (op_valid) begin
                res_data <= shift_res;
                res_dst  <= dst_sel;
            end
        end
    end

    assign flag_dc = cur_flags.dc;
    assign flag_n  = cur_flags.n;
    assign flag_z  = cur_flags.z;
    assign flag_v  = cur_flags.v;
    assign flag_gt = cur_flags.gt;

    assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && amount == '0 |=> res_data == $past(src_data));

    assert_cond_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_cond |=> $stable({flag_dc, flag_n, flag_z, flag_v, flag_gt}));

    assert_n_tracks_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_cond |=> flag_n == res_data[DATA_W-1] && flag_z == (res_data == '0));

    assert_v_gt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_v && !flag_gt);

    assert_bad_amount_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && amount == AMT_W'(MAX_SHIFT + 1) |=> amt_bad);

    assert_imm_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_imm && src1_sel != dst_sel |=> imm_mismatch);

    assert_dst_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid && res_dst == $past(dst_sel));
endmodule

// File: tb/ashift_flag_unit_test.sv
module ashift_flag_unit_test;
    localparam int DW = 40;
    localparam int AW = 7;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0, op_cond = 1'b0, op_imm = 1'b0;
    logic [RW-1:0] src1_sel = '0, dst_sel = '0;
    logic [DW-1:0] src_data = '0;
    logic [AW-1:0] amount = '0;
    logic [2:0]    cond_sel = '0;
    logic          res_valid, amt_bad, imm_mismatch;
    logic [DW-1:0] res_data;
    logic [RW-1:0] res_dst;
    logic          flag_dc, flag_n, flag_z, flag_v, flag_gt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [4:0] m_flags = '0;

    always #5 clk = ~clk;

    ashift_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cond(op_cond),
        .op_imm(op_imm), .src1_sel(src1_sel), .dst_sel(dst_sel),
        .src_data(src_data), .amount(amount), .cond_sel(cond_sel),
        .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst),
        .amt_bad(amt_bad), .imm_mismatch(imm_mismatch), .flag_dc(flag_dc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int p);
        case (p)
            0: return 40'h00_0000_0001;
            1: return 40'hFF_FFFF_FFFF;
            2: return 40'h80_0000_0000;
            3: return 40'h7F_FFFF_FFFF;
            4: return 40'h12_3456_789A;
            default: return 40'hA5_5AA5_5A3C;
        endcase
    endfunction

    task automatic run_op(input int amt, input logic [DW-1:0] src, input logic [2:0] cs,
                          input bit cond, input bit imm, input logic [RW-1:0] s1,
                          input logic [RW-1:0] d);
        bit bad;
        logic [DW-1:0] e_res;
        logic e_sh, e_dc, e_neg, e_zero;
        logic [127:0] prod;
        longint v, p, r;
        bad = (amt < -32) || (amt > 32);
        e_res = src;
        e_sh = 1'b0;
        if (amt > 0) begin
            prod = {88'b0, src} * (128'd1 << amt);
            e_res = prod[DW-1:0];
            e_sh = prod[DW];
        end else if (amt < 0) begin
            v = longint'($signed(src));
            p = longint'(1) << (-amt);
            r = v % p;
            if (r < 0) r = r + p;
            v = (v - r) / p;
            e_res = v[DW-1:0];
            e_sh = (-amt <= DW) ? src[-amt-1] : src[DW-1];
        end
        e_neg = e_res[DW-1];
        e_zero = (e_res == '0);
        case (cs)
            3'b000: e_dc = e_sh;
            3'b001: e_dc = e_neg;
            3'b010: e_dc = e_zero;
            default: e_dc = 1'b0;
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_cond = cond; op_imm = imm; src1_sel = s1; dst_sel = d;
        src_data = src; amount = AW'(amt); cond_sel = cs;
        @(negedge clk);
        if (!cond) m_flags = {e_dc, e_neg, e_zero, 2'b00};
        chk("R1 res_valid", 64'(res_valid), 64'd1);
        chk("R1 res_dst", 64'(res_dst), 64'(d));
        chk("R4 amt_bad", 64'(amt_bad), 64'(bad));
        chk("R5 imm_mismatch", 64'(imm_mismatch), 64'(imm && (s1 != d)));
        if (!bad) begin
            if (amt > 0) chk("R1 left result", 64'(res_data), 64'(e_res));
            else if (amt < 0) chk("R2 right result", 64'(res_data), 64'(e_res));
            else chk("R3 zero-count pass", 64'(res_data), 64'(e_res));
        end
        if (cond) chk("R7 flags held", 64'({flag_dc, flag_n, flag_z, flag_v, flag_gt}), 64'(m_flags));
        else if (cs == 3'b000) chk("R8 dc shifted-out", 64'(flag_dc), 64'(e_dc));
        else if (cs == 3'b001 || cs == 3'b010) chk("R9 dc sign/zero", 64'(flag_dc), 64'(e_dc));
        else chk("R10 dc cleared", 64'(flag_dc), 64'd0);
        if (!cond) begin
            chk("R6 flags written", 64'({flag_dc, flag_n, flag_z, flag_v, flag_gt}), 64'(m_flags));
            chk("R11 n z v gt", 64'({flag_n, flag_z, flag_v, flag_gt}), 64'({e_neg, e_zero, 2'b00}));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset res_valid", 64'(res_valid), 64'd0);
        chk("R12 reset flags", 64'({flag_dc, flag_n, flag_z, flag_v, flag_gt, amt_bad, imm_mismatch}), 64'd0);
        rst_n = 1'b1;
        for (int a = -64; a <= 63; a++) begin
            for (int pi = 0; pi < 6; pi++) begin
                bit bad_a;
                bad_a = (a < -32) || (a > 32);
                run_op(a, pattern(pi), 3'((a + 64 + pi) % 8), (pi == 5) || bad_a,
                       pi[0], RW'(pi), (pi == 3) ? RW'(5) : RW'(pi));
            end
        end
        run_op(0, 40'h55_0000_00AA, 3'b000, 1'b0, 1'b1, 3'd2, 3'd2);
        chk("R3 shifted-out zero", 64'(flag_dc), 64'd0);
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R12 idle res_valid", 64'(res_valid), 64'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule